// File: doc/BRIEF.md
# ADC Calibration Trigger Controller

This block decides when the on-chip converter calibration runs. It lives in the sampling-clock domain and has two sources of work. The first is an automatic run after power-on reset: it is issued once a wait has elapsed, and a delay-select input picks a short or a long wait. The second is an on-command run, which a qualified pattern on the external calibration pin starts: the pin must be low for a minimum number of cycles and then high for a minimum number of cycles. When register-control mode is on, a register calibration bit is ORed into the pin path, and the same qualification applies to the combined signal.

The outputs are a one-cycle `cal_req` pulse and a `cal_busy` flag. The flag models the calibration engine as a fixed-length busy period. Triggers that mature while the engine is busy are dropped. If the pin is held high at the end of the power-on wait, the automatic run is skipped. The inputs pass through a parameterised synchroniser with `SYNC_STAGES` flops, each reset to high, before any decision is made.

Top module: `adc_cal_trigger`

## Requirements
- R1: While `rst_n` is low, `cal_req` and `cal_busy` are both 0.
- R2: If `dly_sel` is 0 at the first rising edge after reset release, the power-on `cal_req` is high after exactly `WAIT_SHORT` edges, counting that first edge as edge 1.
- R3: If `dly_sel` is 1 at that first edge, the power-on `cal_req` comes after exactly `WAIT_LONG` edges.
- R4: If the synchronised calibration pin is high at the edge that ends the power-on wait, no power-on request is issued. On-command triggering is still enabled from then on.
- R5: Let L be the number of consecutive edges at which the synchronised trigger is low, and let the next H edges sample it high. When L ≥ `LOW_MIN` and H reaches `HIGH_MIN`, exactly one `cal_req` is issued. It is registered at the edge that evaluates the `HIGH_MIN`-th high sample, and that edge comes `SYNC_STAGES` edges after the input was sampled.
- R6: A low run shorter than `LOW_MIN` edges does not arm the trigger.
- R7: A high run shorter than `HIGH_MIN` edges issues nothing. Any low run that follows must again reach `LOW_MIN` on its own.
- R8: The trigger is `cal_pin | (reg_mode & cal_reg_bit)`. When `reg_mode` is 0, `cal_reg_bit` has no effect on either output.
- R9: `cal_req` lasts one cycle. `cal_busy` rises together with it and stays high for exactly `BUSY_LEN` cycles.
- R10: A qualified trigger that matures while `cal_busy` is high is dropped, and it does not fire later.
- R11: A trigger held high issues one request only. A new request needs a fresh low run of at least `LOW_MIN`.
- R12: On-command patterns that mature before the power-on wait has ended are ignored.
- R13: `dly_sel` is sampled only at the first edge after reset. Later changes do not alter the wait.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling-domain clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous assert |
| cal_pin | input | 1 | External calibration pin |
| cal_reg_bit | input | 1 | Calibration bit from the control register |
| reg_mode | input | 1 | Register-control mode enable; gates `cal_reg_bit` |
| dly_sel | input | 1 | Power-on wait select: 0 short, 1 long |
| cal_req | output | 1 | One-cycle calibration request |
| cal_busy | output | 1 | High while the modelled calibration runs |

## Verification
A wrong low or high run count shows up at the port when a request is missing, or when it comes one edge early or late. Such a fault is visible within `HIGH_MIN + SYNC_STAGES` cycles of the pin's rising edge. A bad power-on counter or delay latch moves the first request away from edge `WAIT_SHORT` or `WAIT_LONG`. A lost armed flag or busy count produces an extra or missing pulse, or a busy window that is not `BUSY_LEN` cycles long. A cycle-accurate bench model compares both outputs on every cycle, so any such divergence is caught in the cycle where it first appears.

// File: rtl/adc_cal_pkg.sv
package adc_cal_pkg;
   typedef enum logic [1:0] {
      PH_START = 2'd0,
      PH_WAIT  = 2'd1,
      PH_DONE  = 2'd2
   } por_phase_t;
endpackage

// File: rtl/adc_cal_in_sync.sv
module adc_cal_in_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   input  logic trig,
   output logic pin_s,
   output logic trig_s
);
   localparam int SW = 2 * STAGES;
   logic [SW-1:0] sh;

   // Reset to high so that nothing can arm before real samples arrive.
   if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n) sh <= '1;
         else        sh <= {pin, trig};
   end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n) sh <= '1;
         else        sh <= {sh[SW-3:0], pin, trig};
   end

   assign pin_s  = sh[SW-1];
   assign trig_s = sh[SW-2];
endmodule

// File: rtl/adc_cal_pulse_qual.sv
module adc_cal_pulse_qual #(
   parameter int LOW_MIN  = 80,
   parameter int HIGH_MIN = 80
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig_s,
   output logic hit
);
   localparam int LW = $clog2(LOW_MIN + 1);
   localparam int HW = $clog2(HIGH_MIN + 1);
   localparam logic [LW-1:0] LOW_SAT = LW'(LOW_MIN);
   localparam logic [HW-1:0] HI_SAT  = HW'(HIGH_MIN);
   localparam logic [HW-1:0] HI_LAST = HW'(HIGH_MIN - 1);

   logic [LW-1:0] low_cnt;
   logic [HW-1:0] hi_cnt;
   logic          armed;

   assign hit = trig_s & armed & (hi_cnt == HI_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_cnt <= '0;
         hi_cnt  <= '0;
         armed   <= 1'b0;
      end else if (trig_s) begin
         low_cnt <= '0;
         if (hi_cnt != HI_SAT) hi_cnt <= hi_cnt + 1'b1;
         // The qualifying edge consumes the arm whether or not it is used.
         if (hi_cnt == HI_LAST) armed <= 1'b0;
      end else begin
         hi_cnt <= '0;
         if (low_cnt != LOW_SAT) low_cnt <= low_cnt + 1'b1;
         armed <= (int'(low_cnt) >= LOW_MIN - 1);
      end
   end
endmodule

// File: rtl/adc_cal_por_timer.sv
module adc_cal_por_timer
   import adc_cal_pkg::*;
#(
   parameter int WAIT_SHORT = 1024,
   parameter int WAIT_LONG  = 16384
) (
   input  logic clk,
   input  logic rst_n,
   input  logic dly_sel,
   input  logic pin_s,
   output logic por_hit,
   output logic por_done
);
   localparam int WMAX = (WAIT_SHORT > WAIT_LONG) ? WAIT_SHORT : WAIT_LONG;
   localparam int CW   = $clog2(WMAX + 1);
   localparam logic [CW-1:0] SHORT_LAST = CW'(WAIT_SHORT - 1);
   localparam logic [CW-1:0] LONG_LAST  = CW'(WAIT_LONG - 1);

   por_phase_t    phase;
   logic [CW-1:0] cnt;
   logic [CW-1:0] last;

   if (WAIT_SHORT == WAIT_LONG) begin : g_fixed
      logic unused_dly;
      assign unused_dly = dly_sel;
      assign last = SHORT_LAST;
   end else begin : g_select
      logic dly_q;
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n)                 dly_q <= 1'b0;
         else if (phase == PH_START) dly_q <= dly_sel;
      assign last = dly_q ? LONG_LAST : SHORT_LAST;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_START;
         cnt   <= '0;
      end else begin
         case (phase)
            PH_START: begin
               phase <= PH_WAIT;
               cnt   <= CW'(1);
            end
            PH_WAIT: begin
               cnt <= cnt + 1'b1;
               if (cnt == last) phase <= PH_DONE;
            end
            default: phase <= PH_DONE;
         endcase
      end
   end

   assign por_hit  = (phase == PH_WAIT) && (cnt == last) && !pin_s;
   assign por_done = (phase == PH_DONE);
endmodule

// File: rtl/adc_cal_busy_timer.sv
module adc_cal_busy_timer #(
   parameter int BUSY_LEN = 256
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   localparam int BW = $clog2(BUSY_LEN);
   localparam logic [BW-1:0] LOAD = BW'(BUSY_LEN - 1);

   logic [BW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (start) begin
         busy <= 1'b1;
         cnt  <= LOAD;
      end else if (busy) begin
         if (cnt == '0) busy <= 1'b0;
         else           cnt  <= cnt - 1'b1;
      end
   end
endmodule

// File: rtl/adc_cal_trigger.sv
module adc_cal_trigger #(
   parameter int LOW_MIN     = 80,
   parameter int HIGH_MIN    = 80,
   parameter int WAIT_SHORT  = 1024,
   parameter int WAIT_LONG   = 16384,
   parameter int BUSY_LEN    = 256,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cal_pin,
   input  logic cal_reg_bit,
   input  logic reg_mode,
   input  logic dly_sel,
   output logic cal_req,
   output logic cal_busy
);
   if (LOW_MIN < 1 || HIGH_MIN < 1) begin : g_bad_runs
      $error("adc_cal_trigger: run minima must be at least 1");
   end
   if (WAIT_SHORT < 2 || WAIT_LONG < 2) begin : g_bad_wait
      $error("adc_cal_trigger: power-on waits must be at least 2");
   end
   if (BUSY_LEN < 2) begin : g_bad_busy
      $error("adc_cal_trigger: BUSY_LEN must be at least 2");
   end
   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("adc_cal_trigger: SYNC_STAGES must be at least 1");
   end

   logic trig_raw, pin_s, trig_s;
   logic cmd_hit, por_hit, por_done, fire;

   assign trig_raw = cal_pin | (reg_mode & cal_reg_bit);

   adc_cal_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin(cal_pin), .trig(trig_raw),
      .pin_s(pin_s), .trig_s(trig_s)
   );

   adc_cal_pulse_qual #(.LOW_MIN(LOW_MIN), .HIGH_MIN(HIGH_MIN)) u_qual (
      .clk(clk), .rst_n(rst_n), .trig_s(trig_s), .hit(cmd_hit)
   );

   adc_cal_por_timer #(.WAIT_SHORT(WAIT_SHORT), .WAIT_LONG(WAIT_LONG)) u_por (
      .clk(clk), .rst_n(rst_n), .dly_sel(dly_sel), .pin_s(pin_s),
      .por_hit(por_hit), .por_done(por_done)
   );

   assign fire = !cal_busy && (por_hit || (cmd_hit && por_done));

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) cal_req <= 1'b0;
      else        cal_req <= fire;

   adc_cal_busy_timer #(.BUSY_LEN(BUSY_LEN)) u_busy (
      .clk(clk), .rst_n(rst_n), .start(fire), .busy(cal_busy)
   );
endmodule

// File: rtl/adc_cal_trigger_chk.sv
module adc_cal_trigger_chk #(
   parameter int WAIT_SHORT = 1024,
   parameter int WAIT_LONG  = 16384,
   parameter int BUSY_LEN   = 256
) (
   input logic clk,
   input logic rst_n,
   input logic cal_req,
   input logic cal_busy
);
   localparam int WMIN = (WAIT_SHORT < WAIT_LONG) ? WAIT_SHORT : WAIT_LONG;
   localparam int EW   = $clog2(WMIN + 1);
   localparam int RW   = $clog2(BUSY_LEN + 2);

   logic [EW-1:0] edges;
   logic [RW-1:0] run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         edges <= '0;
         run   <= '0;
      end else begin
         if (int'(edges) != WMIN) edges <= edges + 1'b1;
         if (!cal_busy)                   run <= '0;
         else if (int'(run) <= BUSY_LEN)  run <= run + 1'b1;
      end
   end

   // R9
   req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cal_req |=> !cal_req);

   // R9
   busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cal_busy) |-> cal_req);

   // R9
   busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cal_busy) |-> (int'(run) == BUSY_LEN));

   // R10
   no_req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cal_req |-> !$past(cal_busy));

   // R12
   por_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cal_req |-> (int'(edges) >= WMIN));
endmodule

bind adc_cal_trigger adc_cal_trigger_chk #(
   .WAIT_SHORT(WAIT_SHORT), .WAIT_LONG(WAIT_LONG), .BUSY_LEN(BUSY_LEN)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cal_req(cal_req), .cal_busy(cal_busy)
);

// File: tb/tb_adc_cal_trigger.sv
module tb_adc_cal_trigger;
   localparam int LOW  = 8;
   localparam int HIGH = 6;
   localparam int WS   = 40;
   localparam int WL   = 120;
   localparam int BL   = 20;
   localparam int SS   = 2;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cal_pin = 1'b0, cal_reg_bit = 1'b0, reg_mode = 1'b0, dly_sel = 1'b0;
   logic cal_req, cal_busy;

   always #10 clk = ~clk;

   adc_cal_trigger #(
      .LOW_MIN(LOW), .HIGH_MIN(HIGH), .WAIT_SHORT(WS), .WAIT_LONG(WL),
      .BUSY_LEN(BL), .SYNC_STAGES(SS)
   ) dut (
      .clk(clk), .rst_n(rst_n), .cal_pin(cal_pin), .cal_reg_bit(cal_reg_bit),
      .reg_mode(reg_mode), .dly_sel(dly_sel), .cal_req(cal_req), .cal_busy(cal_busy)
   );

   int    n_tests = 0, n_fail = 0;
   string cur_tag = "R1";
   bit    wd_hit = 1'b0;

   task automatic check_eq(string tag, int act, int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   // Expected behaviour from the requirements, one step per rising edge.
   logic [SS-1:0] h_trig, h_pin;
   int  k, lim, hrun, lrun, mcnt;
   bit  prev_hi, done, mbusy, exp_req, old_t, old_p, fire, done_n;

   always @(posedge clk) begin
      if (!rst_n) begin
         h_trig = '1; h_pin = '1; k = 0; lim = WS; hrun = 0; lrun = 0;
         prev_hi = 1'b1; done = 1'b0; mbusy = 1'b0; mcnt = 0; exp_req = 1'b0;
      end else begin
         old_t = h_trig[SS-1];
         old_p = h_pin[SS-1];
         fire = 1'b0;
         done_n = done;
         k++;
         if (k == 1) lim = dly_sel ? WL : WS;
         if (!done && k == lim) begin
            done_n = 1'b1;
            if (!old_p && !mbusy) fire = 1'b1;
         end
         if (old_t) begin
            if (!prev_hi) hrun = 0;
            hrun++;
            if (hrun == HIGH && lrun >= LOW && done && !mbusy) fire = 1'b1;
         end else begin
            if (prev_hi) lrun = 0;
            lrun++;
         end
         prev_hi = old_t;
         done = done_n;
         if (fire) begin
            mbusy = 1'b1; mcnt = BL - 1;
         end else if (mbusy) begin
            if (mcnt == 0) mbusy = 1'b0;
            else mcnt--;
         end
         exp_req = fire;
         h_trig = {h_trig[SS-2:0], cal_pin | (reg_mode & cal_reg_bit)};
         h_pin  = {h_pin[SS-2:0], cal_pin};
      end
   end

   int npulse = 0, first_edge = -1, brun = 0;
   always @(negedge clk) begin
      if (rst_n && !wd_hit) begin
         check_eq(cur_tag, int'(cal_req), int'(exp_req));
         check_eq(cur_tag, int'(cal_busy), int'(mbusy));
         if (cal_req) begin
            npulse++;
            if (first_edge < 0) first_edge = k;
         end
         if (cal_busy) brun++;
         else begin
            if (brun != 0) check_eq("R9 busy length", brun, BL);
            brun = 0;
         end
      end
   end

   task automatic step(bit p, bit rb, bit rm, int n);
      @(negedge clk);
      cal_pin = p; cal_reg_bit = rb; reg_mode = rm;
      repeat (n - 1) @(negedge clk);
   endtask

   task automatic settle();
      @(negedge clk);
      #1;
   endtask

   task automatic do_reset(bit d, bit p);
      @(negedge clk);
      rst_n = 1'b0; dly_sel = d; cal_pin = p; cal_reg_bit = 1'b0; reg_mode = 1'b0;
      repeat (3) @(negedge clk);
      // R1
      check_eq("R1 req in reset", int'(cal_req), 0);
      check_eq("R1 busy in reset", int'(cal_busy), 0);
      rst_n = 1'b1;
      npulse = 0; first_edge = -1; brun = 0;
   endtask

   initial begin
      int m0;
      // R2 and R13: short wait, dly_sel changed after the first edge
      cur_tag = "R2";
      do_reset(1'b0, 1'b0);
      step(0, 0, 0, 5);
      dly_sel = 1'b1;
      step(0, 0, 0, 60);
      settle();
      check_eq("R2 first request edge", first_edge, WS);
      check_eq("R13 late dly_sel ignored", first_edge, WS);
      check_eq("R2 request count", npulse, 1);

      // R3 and R12: long wait, early pattern ignored
      cur_tag = "R12";
      do_reset(1'b1, 1'b0);
      step(0, 0, 0, 20);
      step(1, 0, 0, 8);
      step(0, 0, 0, 102);
      settle();
      check_eq("R3 first request edge", first_edge, WL);
      check_eq("R12 early pattern ignored", npulse, 1);

      // R4: pin high through power-on
      cur_tag = "R4";
      do_reset(1'b0, 1'b1);
      step(1, 0, 0, 60);
      settle();
      check_eq("R4 power-on run suppressed", npulse, 0);

      // R5 and R11: qualified pattern, then held high
      cur_tag = "R5";
      m0 = npulse;
      step(0, 0, 0, 10);
      step(1, 0, 0, 30);
      settle();
      check_eq("R5 one request", npulse - m0, 1);
      check_eq("R11 held high gives one", npulse - m0, 1);

      // R6: low run too short
      cur_tag = "R6";
      m0 = npulse;
      step(0, 0, 0, LOW - 3);
      step(1, 0, 0, 10);
      settle();
      check_eq("R6 short low ignored", npulse - m0, 0);

      // R7: high run too short, then a short low
      cur_tag = "R7";
      m0 = npulse;
      step(0, 0, 0, 10);
      step(1, 0, 0, HIGH - 2);
      step(0, 0, 0, 3);
      step(1, 0, 0, 10);
      settle();
      check_eq("R7 short high ignored", npulse - m0, 0);

      // R11: fresh low re-arms
      cur_tag = "R11";
      m0 = npulse;
      step(0, 0, 0, 10);
      step(1, 0, 0, 30);
      settle();
      check_eq("R11 re-armed request", npulse - m0, 1);

      // R8: register bit ORed in register mode, no effect otherwise
      cur_tag = "R8";
      m0 = npulse;
      step(0, 0, 1, 10);
      step(0, 1, 1, 8);
      step(0, 0, 1, 25);
      settle();
      check_eq("R8 register bit triggers", npulse - m0, 1);
      m0 = npulse;
      step(0, 0, 0, 10);
      step(0, 1, 0, 10);
      step(0, 0, 0, 10);
      step(0, 1, 0, 10);
      step(0, 0, 0, 5);
      settle();
      check_eq("R8 bit ignored without mode", npulse - m0, 0);
      check_eq("R8 busy stays low", int'(cal_busy), 0);

      // R10: second trigger while busy
      cur_tag = "R10";
      step(1, 0, 0, 3);
      m0 = npulse;
      step(0, 0, 0, 10);
      step(1, 0, 0, HIGH);
      step(0, 0, 0, 9);
      step(1, 0, 0, HIGH);
      step(0, 0, 0, 40);
      settle();
      check_eq("R10 busy trigger dropped", npulse - m0, 1);

      // Random runs checked against the model every cycle
      cur_tag = "R5 random";
      void'($urandom(32'd1234));
      for (int i = 0; i < 200; i++) begin
         step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
              1'($urandom_range(0, 1)), $urandom_range(1, 14));
      end
      settle();

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      wd_hit = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule